// File: doc/BRIEF.md
# Warp Load Coalescer

This block sits between a warp's load issue stage and the memory port. It takes one warp-wide load request, made of 32 lane byte addresses and a mask of active lanes, and splits it into the smallest set of aligned 128-byte memory transactions. Each lane reads one 4-byte word. All active lanes whose addresses fall in the same 128-byte segment share one transaction. A warp whose lanes read consecutive words from an aligned base therefore costs one transaction. A warp whose lanes all land in different segments costs one transaction per active lane, up to 32.

Both streams use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a request being offered waits until the previous one has fully drained. Transactions come out one per cycle. Once `txn_valid` is raised it stays high, and its payload stays frozen, until a cycle with `txn_ready` high consumes it. A one-cycle `done` pulse closes every request. `txn_count` then holds the number of transactions that were issued.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. While a request is in progress, `req_valid`, `req_addr` and `req_mask` have no effect on any transaction or on the final count.
- R2: The segment of an address is that address with bits [6:0] cleared. `txn_base` is a segment address, and every lane set in `txn_lanes` (bit i means lane i, address bits [32*i+31:32*i] of `req_addr`) has an address in that segment.
- R3: Each transaction serves every not-yet-served active lane of its segment. The lane sets of one request are non-empty and disjoint, and together they equal the active mask.
- R4: The number of transactions equals the number of distinct segments among the active lanes. A fully contiguous warp from an aligned base takes 1 transaction; 32 lanes in 32 distinct segments take 32.
- R5: Transactions are ordered by the lowest-numbered active lane still unserved. The lowest set bit of `txn_lanes` strictly increases across the transactions of a request.
- R6: Inactive lanes never appear in `txn_lanes`. A request with an all-zero mask issues no transaction and still produces `done`.
- R7: While `txn_valid` is high and `txn_ready` is low, on the next cycle `txn_valid` is still high and `txn_base` and `txn_lanes` are unchanged.
- R8: With `txn_ready` held high, a request that needs n transactions raises `done` n+1 cycles after the acceptance edge (one cycle, plus one per transaction).
- R9: `done` is high for a single cycle. `txn_count` goes to 0 on acceptance, rises by 1 on every consumed transaction, and holds its final value until the next acceptance.
- R10: After reset, `req_ready` is 1 and `txn_valid`, `done` and `txn_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side accepts the transaction |
| txn_base | output | 32 | 128-byte aligned segment address |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_count | output | 6 | Transactions issued for the current or last request |
| done | output | 1 | One-cycle pulse when a request has fully drained |

## Verification
The hardest case to reach from the ports is a memory-side stall that lands partway through a long drain while a different request is already waiting at the input. A stall like that must freeze the offered transaction. The waiting request must not leak into the lane sets or the count. To create it, the stimulus keeps `req_valid` high with unrelated addresses and a full mask for the whole time a request is draining, and it drives `txn_ready` from a pseudo-random sequence. Stride sweeps from 0 to 40 words at several base offsets then walk the transaction count from 1 up to 32.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ISSUE = 2'd1,
    CS_FIN   = 2'd2
  } coal_state_e;

  // Mask that keeps only the segment part of an address.
  function automatic logic [31:0] seg_keep_mask(input int seg_bits);
    logic [31:0] m;
    m = '1;
    m = m << seg_bits;
    return m;
  endfunction

endpackage

// File: rtl/coal_leader_pick.sv
// Finds the lowest-numbered lane still waiting to be served.
module coal_leader_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] leader,
  output logic             any_pend
);

  always_comb begin
    leader = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) leader = IDX_W'(i);
    end
  end

  assign any_pend = |pend;

endmodule

// File: rtl/coal_seg_match.sv
// Compares every lane's segment with the leader's segment, in parallel.
module coal_seg_match #(
  parameter int LANES    = 32,
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 7,
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             pend,
  input  logic [IDX_W-1:0]             leader,
  output logic [ADDR_W-1:0]            base,
  output logic [LANES-1:0]             lanes
);

  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << SEG_BITS;

  logic [ADDR_W-1:0] lead_seg;

  assign lead_seg = addr[leader] & KEEP;
  assign base     = lead_seg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = pend[g] && ((addr[g] & KEEP) == lead_seg);
  end

endmodule

// File: rtl/coal_issue_ctrl.sv
// Request capture, pending-lane bookkeeping, sequencing and counting.
module coal_issue_ctrl #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [LANES-1:0][ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]             req_mask,
  input  logic                         txn_ready,
  input  logic [LANES-1:0]             served,
  output logic [LANES-1:0][ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]             pend_q,
  output logic                         req_ready,
  output logic                         txn_valid,
  output logic                         done,
  output logic [CNT_W-1:0]             cnt_q
);
  import coal_pkg::*;

  coal_state_e       state_q;
  logic [LANES-1:0]  pend_after;

  assign pend_after = pend_q & ~served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        CS_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            pend_q  <= req_mask;
            cnt_q   <= '0;
            state_q <= (req_mask == '0) ? CS_FIN : CS_ISSUE;
          end
        end
        CS_ISSUE: begin
          if (txn_ready) begin
            pend_q <= pend_after;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (pend_after == '0) state_q <= CS_FIN;
          end
        end
        CS_FIN:  state_q <= CS_IDLE;
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == CS_IDLE);
  assign txn_valid = (state_q == CS_ISSUE);
  assign done      = (state_q == CS_FIN);

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES    = 32,
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 7,
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [LANES-1:0]        txn_lanes,
  output logic [CNT_W-1:0]        txn_count,
  output logic                    done
);

  logic [LANES-1:0][ADDR_W-1:0] addr_in;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0]             match;
  logic [IDX_W-1:0]             leader;
  logic                         any_pend;

  assign addr_in = req_addr;

  coal_issue_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (addr_in),
    .req_mask  (req_mask),
    .txn_ready (txn_ready),
    .served    (match),
    .addr_q    (addr_q),
    .pend_q    (pend_q),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .done      (done),
    .cnt_q     (txn_count)
  );

  coal_leader_pick #(.LANES(LANES)) u_pick (
    .pend     (pend_q),
    .leader   (leader),
    .any_pend (any_pend)
  );

  coal_seg_match #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_match (
    .addr   (addr_q),
    .pend   (pend_q),
    .leader (leader),
    .base   (txn_base),
    .lanes  (match)
  );

  assign txn_lanes = any_pend ? match : '0;

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LANES    = 32,
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 7,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_mask,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_base,
  input logic [LANES-1:0]  txn_lanes,
  input logic [CNT_W-1:0]  txn_count,
  input logic              done
);

  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (req_valid && req_ready) mask_q <= req_mask;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_lanes));

  // R3
  lanes_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_lanes != '0);

  // R6
  lanes_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes & ~mask_q) == '0);

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_base[SEG_BITS-1:0] == '0);

  // R1
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> txn_count == $past(txn_count) + CNT_W'(1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

endmodule

bind warp_coalescer coal_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mask  (req_mask),
  .txn_valid (txn_valid),
  .txn_ready (txn_ready),
  .txn_base  (txn_base),
  .txn_lanes (txn_lanes),
  .txn_count (txn_count),
  .done      (done)
);

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;

  localparam int LANES = 32;
  localparam int AW    = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [AW-1:0]   txn_base;
  logic [LANES-1:0] txn_lanes;
  logic [5:0]      txn_count;
  logic            done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [31:0] cur_addr [LANES];
  logic [LANES-1:0] cur_mask;

  always #2 clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_lanes(txn_lanes),
    .txn_count(txn_count), .done(done)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_count();
    int n;
    n = 0;
    for (int i = 0; i < LANES; i++) begin
      bit seen;
      seen = 0;
      if (cur_mask[i]) begin
        for (int j = 0; j < i; j++)
          if (cur_mask[j] && (cur_addr[j] >> 7) == (cur_addr[i] >> 7)) seen = 1;
        if (!seen) n++;
      end
    end
    return n;
  endfunction

  task automatic run_req(input bit rand_ready);
    int exp_n, ntx, cyc, last_low;
    logic [LANES-1:0] served;
    bit seg_ok, disj_ok, order_ok, stab_ok, busy_ok, prev_stall;
    logic [AW-1:0] prev_base;
    logic [LANES-1:0] prev_lanes;
    exp_n = ref_count();
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready when idle", req_ready, 1);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = cur_addr[i];
    req_mask  = cur_mask;
    req_valid = 1'b1;
    @(posedge clk);
    ntx = 0; cyc = 0; last_low = -1; served = '0;
    seg_ok = 1; disj_ok = 1; order_ok = 1; stab_ok = 1; busy_ok = 1;
    prev_stall = 0; prev_base = '0; prev_lanes = '0;
    forever begin
      @(negedge clk);
      cyc++;
      // unrelated request kept on offer while busy (R1)
      req_addr = {LANES{32'hDEAD_0000 + AW'(cyc * 132)}};
      req_mask = '1;
      if (prev_stall && !(txn_valid && txn_base == prev_base && txn_lanes == prev_lanes))
        stab_ok = 0;
      if (done || cyc > 400) break;
      if (req_ready) busy_ok = 0;
      if (rand_ready) begin
        rng = next_rng(rng);
        txn_ready = rng[3] | rng[7];
      end else txn_ready = 1'b1;
      prev_stall = txn_valid && !txn_ready;
      prev_base = txn_base; prev_lanes = txn_lanes;
      if (txn_valid && txn_ready) begin
        int low;
        low = -1;
        for (int i = LANES - 1; i >= 0; i--) if (txn_lanes[i]) low = i;
        if (low <= last_low) order_ok = 0;
        last_low = low;
        if ((txn_lanes & served) != '0 || txn_lanes == '0) disj_ok = 0;
        if (txn_base[6:0] != 7'd0) seg_ok = 0;
        for (int i = 0; i < LANES; i++)
          if (txn_lanes[i] && (cur_addr[i] & 32'hFFFF_FF80) != txn_base) seg_ok = 0;
        // every unserved active lane of this segment must be in the set (R3)
        for (int i = 0; i < LANES; i++)
          if (cur_mask[i] && !served[i] && !txn_lanes[i] &&
              (cur_addr[i] & 32'hFFFF_FF80) == txn_base) disj_ok = 0;
        served = served | txn_lanes;
        ntx++;
      end
    end
    check(ntx == exp_n, "R4", "transaction count", ntx, exp_n);
    check(txn_count == 6'(exp_n), "R9", "txn_count at done", txn_count, exp_n);
    check(served == cur_mask, "R3", "union of lanes vs mask", served, cur_mask);
    check((served & ~cur_mask) == '0, "R6", "inactive lanes served", served & ~cur_mask, 0);
    check(seg_ok, "R2", "lanes within segment", seg_ok, 1);
    check(disj_ok, "R3", "disjoint complete lane sets", disj_ok, 1);
    check(order_ok, "R5", "ascending leader order", order_ok, 1);
    check(stab_ok, "R7", "payload held under stall", stab_ok, 1);
    check(busy_ok, "R1", "req_ready low while busy", busy_ok, 1);
    if (!rand_ready) check(cyc == exp_n + 1, "R8", "done latency", cyc, exp_n + 1);
    req_valid = 1'b0;
    txn_ready = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
    check(txn_count == 6'(exp_n), "R9", "txn_count held", txn_count, exp_n);
  endtask

  initial begin
    int w;
    w = 0;
    while (!finished) begin
      @(posedge clk);
      w++;
      if (w > 190000) begin
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", w, 190000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
    check(txn_valid == 1'b0, "R10", "reset txn_valid", txn_valid, 0);
    check(done == 1'b0, "R10", "reset done", done, 0);
    check(txn_count == 6'd0, "R10", "reset txn_count", txn_count, 0);
    rst_n = 1'b1;

    // R6: empty mask
    for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h100 + 32'(i * 4);
    cur_mask = '0;
    run_req(0);
    // R4: aligned contiguous -> 1
    for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h1000 + 32'(i * 4);
    cur_mask = '1;
    run_req(0);
    // R4: misaligned contiguous -> 2
    for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h1004 + 32'(i * 4);
    run_req(1);
    // broadcast -> 1
    for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h2040;
    run_req(0);

    // stride sweep (R4, R5, R8)
    for (int s = 0; s <= 40; s++) begin
      for (int o = 0; o < 4; o++) begin
        int off;
        off = (o == 0) ? 0 : (o == 1) ? 4 : (o == 2) ? 60 : 124;
        for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h8000 + 32'(off) + 32'(i * s * 4);
        cur_mask = '1;
        run_req(o[0]);
      end
    end

    // single active lane over scattered addresses (R6)
    for (int k = 0; k < LANES; k++) begin
      for (int i = 0; i < LANES; i++) cur_addr[i] = 32'h4_0000 + 32'(i * 256);
      cur_mask = LANES'(1) << k;
      run_req(k[0]);
    end

    // clustered random addresses and masks
    for (int r = 0; r < 150; r++) begin
      for (int i = 0; i < LANES; i++) begin
        rng = next_rng(rng);
        cur_addr[i] = 32'h0010_0000 + (rng & 32'h3FC);
      end
      rng = next_rng(rng);
      cur_mask = rng;
      run_req(r[0] | r[1]);
    end

    // wide random addresses
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < LANES; i++) begin
        rng = next_rng(rng);
        cur_addr[i] = rng & 32'hFFFF_FFFC;
      end
      cur_mask = (r < 15) ? '1 : LANES'(rng ^ 32'h5A5A_A5A5);
      run_req(r[0]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule